// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time in packed BCD: seconds, minutes, hours, day of month, month, two-digit year and a weekday counter. A one-cycle pulse on `tick_1hz` advances the time by one second while the run bit is set. Day rollover follows the length of each month, and a leap February is derived from the BCD year. An alarm register set is compared against the calendar on every advance. A sticky status register records rollover events, the alarm match and a power-up marker. An enable register turns those events into a single level interrupt.

Software reaches the block through a byte-wide register port. A write is taken on the clock edge at which `bus_sel` and `bus_we` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_we` is low. Every access completes in one cycle. The port has no back-pressure and no handshake, because no data stream passes through the block.

To read the calendar, software sets the snapshot bit in the control register and then reads the shadow copy. The shadow copy stays frozen until the next snapshot request, so a multi-byte read always sees one instant.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time is 00:00:00 on day 01, month 01, year 00, weekday 0. The control register, interrupt-enable register, alarm registers and compensation registers read 0x00. The status register reads 0x80 (power-up flag in bit 7), and `irq` is low.
- R2: Register offsets: time fields at 0x00 (seconds), 0x01 (minutes), 0x02 (hours), 0x03 (day), 0x04 (month), 0x05 (year) and 0x06 (weekday). Alarm seconds to alarm year sit at 0x07 to 0x0C in the same field order. Control is at 0x0D, status at 0x0E and interrupt enable at 0x0F. The compensation bytes are at 0x10 (low) and 0x11 (high). Unmapped offsets read 0x00.
- R3: Control bit 0 is the run bit. While it is 1, each cycle with `tick_1hz` high advances the time by one second, with BCD carry from seconds to minutes to hours to day. While it is 0, the counters hold. Status bit 1 reads back the run bit.
- R4: Day 01 follows the last day of the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days. Month 12 is followed by month 01 with a year increment, and year 99 is followed by year 00. The weekday counts 0 to 6 and increments on each day rollover.
- R5: Writing the control register with bit 6 set copies all seven live time fields into the shadow registers. Reads of offsets 0x00 to 0x06 return the shadow registers. Bit 6 is not stored and reads as 0.
- R6: Control bits 1 to 5 and both compensation bytes are stored and read back, and they have no other effect.
- R7: Status bits 2, 3, 4 and 5 are set by a seconds advance, a minute rollover, an hour rollover and a day rollover respectively. Each stays set until cleared.
- R8: Writing status clears every flag whose written bit is 1 and leaves the others unchanged. An event that occurs in the same cycle as a clear leaves its flag set.
- R9: Status bit 6 is set by an advance after which seconds, minutes, hours, day, month and year all equal the alarm registers.
- R10: `irq` is high while (status bit 6 and enable bit 3) is true, or while enable bit 2 is set and the event flag selected by enable bits 1:0 is pending. The period codes are 00 = second (bit 2), 01 = minute (bit 3), 10 = hour (bit 4) and 11 = day (bit 5). Enable bits 7:4 read 0.
- R11: A write to a time register in a cycle with `tick_1hz` high takes the written value. No advance happens in that cycle and no event flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest conditions to reach from the ports are the calendar corners: leap and non-leap end of February, a 30-day month end, and the turn of the century. Reaching them by counting seconds would take far too long. The bench therefore stops the clock, loads a time one or two seconds before the boundary through the register port, sets the run bit and applies single ticks. The collision between a time write and a tick is also reached only through deliberate stimulus, by driving both in the same cycle.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int NUM_ALARM  = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam logic [4:0] A_ALARM0 = 5'h07;
  localparam logic [4:0] A_CTRL   = 5'h0D;
  localparam logic [4:0] A_STAT   = 5'h0E;
  localparam logic [4:0] A_IEN    = 5'h0F;
  localparam logic [4:0] A_COMPL  = 5'h10;
  localparam logic [4:0] A_COMPH  = 5'h11;

  typedef logic [NUM_FIELDS-1:0][7:0] rtc_fields_t;

  localparam rtc_fields_t TIME_RST = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = (!yr[4] && (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8)) ||
           ( yr[4] && (yr[3:0] == 4'd2 || yr[3:0] == 4'd6));
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import bcd_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [7:0]  wr_data,
  output rtc_fields_t cur_q,
  output rtc_fields_t nxt,
  output logic [3:0]  ev
);
  // Combinational next-second value; ev = {day, hour, min, sec} rollovers.
  always_comb begin
    nxt = cur_q;
    ev  = 4'b0000;
    if (adv) begin
      ev[0] = 1'b1;
      if (cur_q[F_SEC] == 8'h59) begin
        nxt[F_SEC] = 8'h00;
        ev[1] = 1'b1;
        if (cur_q[F_MIN] == 8'h59) begin
          nxt[F_MIN] = 8'h00;
          ev[2] = 1'b1;
          if (cur_q[F_HOUR] == 8'h23) begin
            nxt[F_HOUR] = 8'h00;
            ev[3] = 1'b1;
            nxt[F_WDAY] = (cur_q[F_WDAY] >= 8'h06) ? 8'h00 : cur_q[F_WDAY] + 8'h01;
            if (cur_q[F_DAY] >= month_len(cur_q[F_MON], cur_q[F_YEAR])) begin
              nxt[F_DAY] = 8'h01;
              if (cur_q[F_MON] >= 8'h12) begin
                nxt[F_MON]  = 8'h01;
                nxt[F_YEAR] = (cur_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur_q[F_YEAR]);
              end else begin
                nxt[F_MON] = bcd_inc(cur_q[F_MON]);
              end
            end else begin
              nxt[F_DAY] = bcd_inc(cur_q[F_DAY]);
            end
          end else begin
            nxt[F_HOUR] = bcd_inc(cur_q[F_HOUR]);
          end
        end else begin
          nxt[F_MIN] = bcd_inc(cur_q[F_MIN]);
        end
      end else begin
        nxt[F_SEC] = bcd_inc(cur_q[F_SEC]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cur_q <= TIME_RST;
    else if (wr_en) cur_q[wr_idx] <= wr_data;
    else            cur_q <= nxt;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import bcd_rtc_pkg::*;
(
  input  rtc_fields_t                 cand,
  input  logic [NUM_ALARM-1:0][7:0]   alarm,
  output logic                        match
);
  logic [NUM_ALARM-1:0] eq;
  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_cmp
    assign eq[i] = (cand[i] == alarm[i]);
  end
  assign match = &eq;
endmodule

// File: rtl/rtc_status_irq.sv
module rtc_status_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ev,
  input  logic       alarm_hit,
  input  logic       clr_en,
  input  logic [7:0] clr_mask,
  input  logic [3:0] ien,
  input  logic       run,
  output logic [7:0] stat,
  output logic       irq
);
  // flags[5:0] hold status bits 7:2
  logic [5:0] flags_q;
  logic [5:0] set_v, clr_v;
  logic       per_flag;

  assign set_v = {1'b0, alarm_hit, ev};
  assign clr_v = clr_en ? clr_mask[7:2] : 6'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= 6'b100000;
    else        flags_q <= (flags_q & ~clr_v) | set_v;
  end

  assign per_flag = flags_q[ien[1:0]];
  assign stat     = {flags_q, run, 1'b0};
  assign irq      = (flags_q[4] & ien[3]) | (per_flag & ien[2]);
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] LAST_TIME = ADDR_W'(NUM_FIELDS - 1);

  rtc_fields_t               live_q, live_nxt, snap_q;
  logic [NUM_ALARM-1:0][7:0] alarm_q;
  logic [5:0]                ctrl_q;
  logic [3:0]                ien_q;
  logic [7:0]                compl_q, comph_q;
  logic [3:0]                ev;
  logic [7:0]                stat_w;
  logic                      wr, time_wr, adv, match, snap_req;
  logic [ADDR_W-1:0]         alarm_off;

  assign wr        = bus_sel & bus_we;
  assign time_wr   = wr & (bus_addr <= LAST_TIME);
  assign adv       = tick_1hz & ctrl_q[0] & ~time_wr;
  assign snap_req  = wr & (bus_addr == A_CTRL) & bus_wdata[6];
  assign alarm_off = bus_addr - A_ALARM0;

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .wr_en(time_wr),
    .wr_idx(bus_addr[2:0]), .wr_data(bus_wdata[7:0]),
    .cur_q(live_q), .nxt(live_nxt), .ev(ev)
  );

  rtc_alarm_cmp u_cmp (.cand(live_nxt), .alarm(alarm_q), .match(match));

  rtc_status_irq u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .alarm_hit(adv & match),
    .clr_en(wr & (bus_addr == A_STAT)), .clr_mask(bus_wdata[7:0]),
    .ien(ien_q), .run(ctrl_q[0]), .stat(stat_w), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= TIME_RST;
      alarm_q <= '0;
      ctrl_q  <= '0;
      ien_q   <= '0;
      compl_q <= '0;
      comph_q <= '0;
    end else begin
      if (snap_req) snap_q <= live_q;
      if (wr) begin
        if (bus_addr >= A_ALARM0 && bus_addr < A_CTRL)
          alarm_q[alarm_off[2:0]] <= bus_wdata[7:0];
        if (bus_addr == A_CTRL)  ctrl_q  <= bus_wdata[5:0];
        if (bus_addr == A_IEN)   ien_q   <= bus_wdata[3:0];
        if (bus_addr == A_COMPL) compl_q <= bus_wdata[7:0];
        if (bus_addr == A_COMPH) comph_q <= bus_wdata[7:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr <= LAST_TIME)
        bus_rdata = DATA_W'(snap_q[bus_addr[2:0]]);
      else if (bus_addr < A_CTRL)
        bus_rdata = DATA_W'(alarm_q[alarm_off[2:0]]);
      else begin
        case (bus_addr)
          A_CTRL:  bus_rdata = DATA_W'({2'b00, ctrl_q});
          A_STAT:  bus_rdata = DATA_W'(stat_w);
          A_IEN:   bus_rdata = DATA_W'({4'b0000, ien_q});
          A_COMPL: bus_rdata = DATA_W'(compl_q);
          A_COMPH: bus_rdata = DATA_W'(comph_q);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        irq,
  input logic        run,
  input rtc_fields_t live,
  input rtc_fields_t snap,
  input logic [7:0]  stat,
  input logic [3:0]  ien
);
  logic wr;
  assign wr = bus_sel & bus_we;

  p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live[F_SEC][3:0] <= 4'd9 && live[F_SEC] <= 8'h59);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(live));

  p_month_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live[F_MON] >= 8'h01 && live[F_MON] <= 8'h12);

  p_wday_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live[F_WDAY] <= 8'h06);

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_CTRL && bus_wdata[6]) |=> $stable(snap));

  p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[6] && !(wr && bus_addr == A_STAT && bus_wdata[6])) |=> stat[6]);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|stat[6:2]));

  p_irq_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[6] && ien[3]) |-> irq);
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .run(ctrl_q[0]),
  .live(live_q), .snap(snap_q), .stat(stat_w), .ien(ien_q)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dy, mo, y, w);
    wr(5'h0D, 8'h00);
    wr(5'h00, s); wr(5'h01, m); wr(5'h02, h); wr(5'h03, dy);
    wr(5'h04, mo); wr(5'h05, y); wr(5'h06, w);
    wr(5'h0D, 8'h01);
  endtask

  task automatic t_reset();
    rdchk("R1 status power-up", 5'h0E, 8'h80);
    rdchk("R1 day reset", 5'h03, 8'h01);
    rdchk("R1 month reset", 5'h04, 8'h01);
    rdchk("R1 ctrl reset", 5'h0D, 8'h00);
    rdchk("R1 alarm reset", 5'h0A, 8'h00);
    chk("R1 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_w1c();
    wr(5'h0E, 8'h00);
    rdchk("R8 zero write keeps flag", 5'h0E, 8'h80);
    wr(5'h0E, 8'h80);
    rdchk("R8 power-up cleared", 5'h0E, 8'h00);
  endtask

  task automatic t_stopped();
    tick(); tick(); tick();
    wr(5'h0D, 8'h40);
    rdchk("R3 frozen seconds", 5'h00, 8'h00);
    rdchk("R3 no events while stopped", 5'h0E, 8'h00);
  endtask

  task automatic t_leap();
    set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h06);
    rdchk("R3 run mirrored", 5'h0E, 8'h02);
    tick(); tick();
    wr(5'h0D, 8'h41);
    rdchk("R3 sec carry", 5'h00, 8'h00);
    rdchk("R3 min carry", 5'h01, 8'h00);
    rdchk("R3 hour carry", 5'h02, 8'h00);
    rdchk("R4 leap feb 29", 5'h03, 8'h29);
    rdchk("R4 month stays feb", 5'h04, 8'h02);
    rdchk("R4 weekday wraps", 5'h06, 8'h00);
    rdchk("R7 all rollover flags", 5'h0E, 8'h3E);
  endtask

  task automatic t_snapshot();
    wr(5'h0E, 8'hFC);
    wr(5'h0D, 8'h41);
    tick();
    rdchk("R5 shadow holds", 5'h00, 8'h00);
    wr(5'h0D, 8'h41);
    rdchk("R5 shadow refreshed", 5'h00, 8'h01);
    rdchk("R5 bit6 reads zero", 5'h0D, 8'h01);
  endtask

  task automatic t_alarm();
    wr(5'h07, 8'h02); wr(5'h08, 8'h00); wr(5'h09, 8'h00);
    wr(5'h0A, 8'h29); wr(5'h0B, 8'h02); wr(5'h0C, 8'h24);
    wr(5'h0F, 8'h08);
    wr(5'h0E, 8'hFC);
    chk("R10 irq idle", {7'b0, irq}, 8'h00);
    tick();
    rdchk("R9 alarm flag", 5'h0E, 8'h46);
    chk("R10 alarm irq", {7'b0, irq}, 8'h01);
    wr(5'h0E, 8'h40);
    chk("R10 irq cleared", {7'b0, irq}, 8'h00);
    rdchk("R8 only alarm cleared", 5'h0E, 8'h06);
  endtask

  task automatic t_alarm_masked();
    wr(5'h07, 8'h03);
    wr(5'h0F, 8'h00);
    tick();
    rdchk("R9 masked alarm flag", 5'h0E, 8'h46);
    chk("R10 masked no irq", {7'b0, irq}, 8'h00);
    wr(5'h0E, 8'hFC);
  endtask

  task automatic t_periodic();
    wr(5'h0F, 8'h05);
    wr(5'h00, 8'h58);
    wr(5'h0E, 8'hFC);
    tick();
    chk("R10 minute period no irq", {7'b0, irq}, 8'h00);
    tick();
    chk("R10 minute period irq", {7'b0, irq}, 8'h01);
    wr(5'h0E, 8'h08);
    chk("R10 minute cleared", {7'b0, irq}, 8'h00);
    wr(5'h0F, 8'h04);
    chk("R10 second period irq", {7'b0, irq}, 8'h01);
    wr(5'h0F, 8'hF0);
    rdchk("R10 enable upper bits zero", 5'h0F, 8'h00);
    chk("R10 disabled irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_write_wins();
    wr(5'h0E, 8'hFC);
    tick_1hz = 1'b1;
    wr(5'h00, 8'h30);
    tick_1hz = 1'b0;
    wr(5'h0D, 8'h41);
    rdchk("R11 write wins", 5'h00, 8'h30);
    rdchk("R11 no event", 5'h0E, 8'h02);
  endtask

  task automatic t_month_ends();
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h03);
    tick(); wr(5'h0D, 8'h41);
    rdchk("R4 non-leap day", 5'h03, 8'h01);
    rdchk("R4 non-leap month", 5'h04, 8'h03);
    rdchk("R4 weekday inc", 5'h06, 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23, 8'h01);
    tick(); wr(5'h0D, 8'h41);
    rdchk("R4 30-day month", 5'h04, 8'h05);
    rdchk("R4 30-day day", 5'h03, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h02);
    tick(); wr(5'h0D, 8'h41);
    rdchk("R4 year wrap", 5'h05, 8'h00);
    rdchk("R4 month wrap", 5'h04, 8'h01);
    rdchk("R4 day wrap", 5'h03, 8'h01);
  endtask

  task automatic t_store();
    wr(5'h0D, 8'h3E);
    rdchk("R6 ctrl stored", 5'h0D, 8'h3E);
    rdchk("R3 run cleared in status", 5'h0E, 8'h3C);
    wr(5'h10, 8'hA5); wr(5'h11, 8'h5A);
    rdchk("R2 R6 comp low", 5'h10, 8'hA5);
    rdchk("R2 R6 comp high", 5'h11, 8'h5A);
    rdchk("R2 unmapped", 5'h15, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_w1c();
    t_stopped();
    t_leap();
    t_snapshot();
    t_alarm();
    t_alarm_masked();
    t_periodic();
    t_write_wins();
    t_month_ends();
    t_store();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule